// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Logic Kit with Demonstration Adder

This block is a small set of dual-rail, return-to-zero logic elements, together with a 4-bit ripple adder built from them. Every logical signal travels as a pair of wires: a true rail and a false rail. One control input, `pre`, is tied to the clock phase and selects between two phases:

- **Precharge** (`pre` high): the input converters and the output register drive both rails of every pair low. That zero then sweeps forward through all of the gates.
- **Evaluation** (`pre` low): exactly one rail of each pair rises, and that rail carries the value.

Each gate is made from positive (non-inverting) functions only:

- **AND:** the true rail is the AND of the true rails, and the false rail is the OR of the false rails.
- **OR:** the dual of AND.
- **XOR:** built from AND-OR terms.
- **NOT:** a plain rail swap, with no logic cell.

The demonstration datapath works as follows. Two single-ended operands and a carry-in pass through input converters, then through a chain of dual-rail full adders. The result, sum plus carry-out, is presented combinationally as rail pairs. The precharge register captures it on a clock edge during evaluation and presents it again as a complementary pair in a later evaluation phase. Because the clock duty cycle gives precharge enough time, every rail pair makes one rise and one fall per cycle, whatever the data.

Top module: `drl_adder_top`

## Requirements
- R1: While `pre` is 1, every combinational result rail (`sum_t`, `sum_f`) is 0, regardless of the operand inputs.
- R2: While `pre` is 0, `sum_t` equals the unsigned value `a_in + b_in + c_in` as a W+1-bit number. The carry-out is bit W. In addition, `sum_f` is the bitwise complement of `sum_t`.
- R3: While `pre` is 1, both registered rails (`q_t`, `q_f`) are 0.
- R4: On a rising clock edge with `pre` at 0, the register stores the true rails of the sum. In the next cycle that has `pre` at 0, `q_t` shows the stored value and `q_f` shows its complement.
- R5: A rising edge with `pre` at 1 leaves the stored value unchanged, whatever happens on the operand inputs during precharge.
- R6: Asynchronous active-low reset clears the stored value to 0. In evaluation after reset, `q_t` is all zeros and `q_f` is all ones.
- R7: In every cycle where `pre` falls to 0, each registered rail pair has exactly one rail high. No pair reads 00 or 11.
- R8: The operand extremes are handled correctly. All-ones plus all-ones plus a carry-in of 1 gives all ones on `sum_t`, including the carry. All-zero operands with no carry give all ones on `sum_f`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the precharge register |
| pre | input | 1 | Phase select: 1 = precharge, 0 = evaluation |
| a_in | input | W | Single-ended operand A |
| b_in | input | W | Single-ended operand B |
| c_in | input | 1 | Single-ended carry-in |
| sum_t | output | W+1 | True rails of the combinational sum (bit W = carry) |
| sum_f | output | W+1 | False rails of the combinational sum |
| q_t | output | W+1 | True rails of the registered sum |
| q_f | output | W+1 | False rails of the registered sum |

## Verification
The assertions check the following on every clock cycle:

- the all-zero wave during precharge on both the combinational and the registered rails;
- complementary rails and the correct arithmetic during evaluation;
- the one-hot state of every registered pair right after `pre` falls;
- the register presenting, at each evaluation, the value captured at the previous evaluation edge.

Some behaviours only the bench scenarios show. These are the value held across several precharge cycles while the operands change, the reset value, back-to-back evaluation cycles, and the full sweep of all operand and carry-in combinations with their extreme cases.

// File: rtl/drl_pkg.sv
package drl_pkg;

  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  function automatic rail_t r_and(rail_t x, rail_t y);
    rail_t o;
    o.t = x.t & y.t;
    o.f = x.f | y.f;
    return o;
  endfunction

  function automatic rail_t r_or(rail_t x, rail_t y);
    rail_t o;
    o.t = x.t | y.t;
    o.f = x.f & y.f;
    return o;
  endfunction

  // inversion is a rail swap: no cell, no extra event
  function automatic rail_t r_not(rail_t x);
    rail_t o;
    o.t = x.f;
    o.f = x.t;
    return o;
  endfunction

  function automatic rail_t r_xor(rail_t x, rail_t y);
    rail_t o;
    o.t = (x.t & y.f) | (x.f & y.t);
    o.f = (x.t & y.t) | (x.f & y.f);
    return o;
  endfunction

  // single-ended to rail pair, zero during precharge
  function automatic rail_t r_launch(logic v, logic pre);
    rail_t o;
    o.t = ~pre & v;
    o.f = ~pre & ~v;
    return o;
  endfunction

endpackage

// File: rtl/drl_in_conv.sv
module drl_in_conv
  import drl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             pre,
  input  logic [W-1:0]     d,
  output rail_t [W-1:0]    r
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign r[i] = r_launch(d[i], pre);
  end
endmodule

// File: rtl/drl_full_add.sv
module drl_full_add
  import drl_pkg::*;
(
  input  rail_t x,
  input  rail_t y,
  input  rail_t ci,
  output rail_t s,
  output rail_t co
);
  rail_t p;
  assign p  = r_xor(x, y);
  assign s  = r_xor(p, ci);
  assign co = r_or(r_and(x, y), r_and(ci, p));
endmodule

// File: rtl/drl_ripple_add.sv
module drl_ripple_add
  import drl_pkg::*;
#(
  parameter int W = 4
) (
  input  rail_t [W-1:0] x,
  input  rail_t [W-1:0] y,
  input  rail_t         ci,
  output rail_t [W:0]   sum
);
  rail_t [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    drl_full_add u_fa (
      .x (x[i]),
      .y (y[i]),
      .ci(c[i]),
      .s (sum[i]),
      .co(c[i+1])
    );
  end

  assign sum[W] = c[W];
endmodule

// File: rtl/drl_preg.sv
module drl_preg
  import drl_pkg::*;
#(
  parameter int W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre,
  input  rail_t [W-1:0] d,
  output rail_t [W-1:0] q
);
  logic [W-1:0] cap;
  logic [W-1:0] st;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign cap[i]  = d[i].t;
    assign q[i]    = r_launch(st[i], pre);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= '0;
    else if (!pre) st <= cap;
  end
endmodule

// File: rtl/drl_adder_top.sv
module drl_adder_top
  import drl_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pre,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W:0]   sum_t,
  output logic [W:0]   sum_f,
  output logic [W:0]   q_t,
  output logic [W:0]   q_f
);
  localparam int RW = W + 1;

  rail_t [W-1:0]  a_r;
  rail_t [W-1:0]  b_r;
  rail_t [0:0]    c_r;
  rail_t [RW-1:0] s_r;
  rail_t [RW-1:0] q_r;

  drl_in_conv #(.W(W)) u_conv_a (.pre(pre), .d(a_in), .r(a_r));
  drl_in_conv #(.W(W)) u_conv_b (.pre(pre), .d(b_in), .r(b_r));
  drl_in_conv #(.W(1)) u_conv_c (.pre(pre), .d(c_in), .r(c_r));

  drl_ripple_add #(.W(W)) u_add (
    .x  (a_r),
    .y  (b_r),
    .ci (c_r[0]),
    .sum(s_r)
  );

  drl_preg #(.W(RW)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .pre  (pre),
    .d    (s_r),
    .q    (q_r)
  );

  for (genvar i = 0; i < RW; i++) begin : g_out
    assign sum_t[i] = s_r[i].t;
    assign sum_f[i] = s_r[i].f;
    assign q_t[i]   = q_r[i].t;
    assign q_f[i]   = q_r[i].f;
  end
endmodule

// File: rtl/drl_adder_chk.sv
module drl_adder_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pre,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         c_in,
  input logic [W:0]   sum_t,
  input logic [W:0]   sum_f,
  input logic [W:0]   q_t,
  input logic [W:0]   q_f
);
  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in};

  a_r1_precharge_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> (sum_t == '0 && sum_f == '0));

  a_r2_eval_complement: assert property (@(posedge clk) disable iff (!rst_n)
    !pre |-> ((sum_t ^ sum_f) == '1 && (sum_t & sum_f) == '0));

  a_r2_eval_sum: assert property (@(posedge clk) disable iff (!rst_n)
    !pre |-> (sum_t == ref_sum));

  a_r3_reg_precharge_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pre |-> (q_t == '0 && q_f == '0));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !pre |=> (pre || (q_t == $past(sum_t) && q_f == ~$past(sum_t))));

  a_r7_one_rail_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre && $past(pre)) |-> ((q_t ^ q_f) == '1 && (q_t & q_f) == '0));
endmodule

bind drl_adder_top drl_adder_chk #(.W(W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .pre  (pre),
  .a_in (a_in),
  .b_in (b_in),
  .c_in (c_in),
  .sum_t(sum_t),
  .sum_f(sum_f),
  .q_t  (q_t),
  .q_f  (q_f)
);

// File: tb/test_drl_adder_top.sv
`timescale 1ns/1ps
module test_drl_adder_top;
  localparam int W  = 4;
  localparam int RW = W + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pre = 1'b1;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          c = 1'b0;
  logic [RW-1:0] sum_t, sum_f, q_t, q_f;

  int            n_run = 0;
  int            n_fail = 0;
  logic [RW-1:0] exp_q[$];
  string         exp_tag[$];
  logic [RW-1:0] last = '0;

  always #4 clk = ~clk;

  drl_adder_top #(.W(W)) i_drl_adder_top (
    .clk(clk), .rst_n(rst_n), .pre(pre),
    .a_in(a), .b_in(b), .c_in(c),
    .sum_t(sum_t), .sum_f(sum_f), .q_t(q_t), .q_f(q_f)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // evaluation cycle: drive operands, check combinational rails, queue register expectation
  task automatic eval_cycle(input logic [W-1:0] av, input logic [W-1:0] bv,
                            input logic cv, input string tag);
    logic [RW-1:0] s;
    @(negedge clk);
    pre = 1'b0; a = av; b = bv; c = cv;
    exp_q.push_back(last);
    exp_tag.push_back(tag);
    s = RW'(av) + RW'(bv) + RW'(cv);
    #1;
    check(sum_t == s,  "R2", "sum true rails",  sum_t, s);
    check(sum_f == ~s, "R2", "sum false rails", sum_f, ~s);
    last = s;
  endtask

  task automatic pre_cycle(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(negedge clk);
    pre = 1'b1; a = av; b = bv; c = cv;
    #1;
    check(sum_t == '0 && sum_f == '0, "R1", "precharge comb rails", {sum_t, sum_f}, 0);
    check(q_t == '0 && q_f == '0,     "R3", "precharge reg rails",  {q_t, q_f}, 0);
  endtask

  // monitor: pops the expected registered value in every evaluation cycle
  always @(negedge clk) begin
    #2;
    if (rst_n && !pre) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "scoreboard empty", 0, 1);
      end else begin
        logic [RW-1:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = exp_tag.pop_front();
        check(q_t == e,  tg, "registered true rails", q_t, e);
        // R7: exactly one rail high per pair
        check(q_f == ~e && (q_t ^ q_f) == '1, "R7", "registered false rails", q_f, ~e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", "run timed out", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R6: reset value shown during evaluation
    pre = 1'b0; a = 4'hF; b = 4'hF; c = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(q_t == '0,  "R6", "reset true rails",  q_t, 0);
    check(q_f == '1, "R6", "reset false rails", q_f, 5'h1F);
    @(negedge clk);
    pre = 1'b1;
    rst_n = 1'b1;
    pre_cycle(4'h0, 4'h0, 1'b0);
    eval_cycle(4'h3, 4'h4, 1'b0, "R6");
    pre_cycle(4'h0, 4'h0, 1'b0);

    // R5: several precharge cycles with changing operands keep 7
    pre_cycle(4'hF, 4'h1, 1'b1);
    pre_cycle(4'hA, 4'h5, 1'b0);
    pre_cycle(4'h9, 4'h9, 1'b1);
    eval_cycle(4'h1, 4'h1, 1'b0, "R5");
    pre_cycle(4'h0, 4'h0, 1'b0);

    // R8: extremes
    eval_cycle(4'hF, 4'hF, 1'b1, "R8");
    pre_cycle(4'h0, 4'h0, 1'b0);
    eval_cycle(4'h0, 4'h0, 1'b0, "R8");
    pre_cycle(4'hF, 4'hF, 1'b1);
    eval_cycle(4'hF, 4'h0, 1'b1, "R8");

    // R4: back-to-back evaluation cycles
    eval_cycle(4'h6, 4'h2, 1'b1, "R4");
    eval_cycle(4'hC, 4'h3, 1'b0, "R4");
    pre_cycle(4'h0, 4'h0, 1'b0);

    // R2: full sweep
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int k = 0; k < 2; k++) begin
          eval_cycle(4'(i), 4'(j), 1'(k), "R4");
          pre_cycle(4'(j), 4'(i), 1'(k ^ 1));
        end

    eval_cycle(4'h0, 4'h0, 1'b0, "R4");
    pre_cycle(4'h0, 4'h0, 1'b0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule